// File: doc/BRIEF.md
# Synchronous Sync-Pair Framing Transmitter

This block frames character-oriented synchronous traffic for a serial line. Before a message, and again between back-to-back messages, it sends a programmable minimum run of two-character sync pairs: the first sync character, then the second. It then hands the message characters one at a time to an internal shift register. One bit goes out on each pulse of the transmit clock enable. The minimum pair count is a small field that software may rewrite at any time. The block samples it only when a new sync run begins.

Messages arrive as a byte stream with a valid/ready handshake and an end-of-message marker. Any block check characters are produced upstream and pass through as ordinary bytes. Each character can be sent least significant bit first or most significant bit first. A line-active flag, in the manner of a request-to-send, covers the whole transmission, from the first sync bit to the final bit of the last message character. While the block is idle, the line rests at mark (logic 1).

If a message underruns, the gap is filled with further whole sync pairs, with no minimum, until the next byte arrives. Likewise, if a sync run completes and no byte is waiting, more whole pairs follow.

Top module: `sync_pair_framer`

## Requirements
- R1: Each sync run holds exactly `pair_cnt`+1 pairs when the first message byte is already valid at the end of the run: 0 gives one pair and 15 gives sixteen.
- R2: A sync pair is always sent whole, as `sync_a` followed by `sync_b`. A message byte never follows a lone `sync_a`.
- R3: `pair_cnt` is sampled only when a sync run starts. Changing it during a run has no effect on that run's length.
- R4: After reset, and whenever no transmission is in progress, `active`=0, `txd`=1 and `in_ready`=0.
- R5: From idle, `in_valid`=1 starts a transmission. `active` rises on the next clock and the first character sent is `sync_a`.
- R6: Message bytes are sent in order, each one after the minimum run. `in_ready` is high only in a cycle with `bit_en`=1 on the final bit of a character, when the block can take a message byte.
- R7: With `msb_first`=1, a character is sent bit 7 first down to bit 0. With `msb_first`=0, it is sent bit 0 first. The setting is captured when the character is loaded.
- R8: Each `bit_en` pulse while active advances exactly one bit. `txd` holds its value in active cycles with no `bit_en`.
- R9: On the final bit of a byte marked `in_last`, a pending `in_valid` starts a new sync run at once. Otherwise `active` falls on the clock edge that ends that final bit.
- R10: If the next byte of a message is not valid at a character boundary, whole sync pairs are inserted until it arrives, and the message then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Transmit clock enable, one pulse per serial bit |
| sync_a | input | 8 | First character of a sync pair |
| sync_b | input | 8 | Second character of a sync pair |
| pair_cnt | input | 4 | Minimum number of pairs minus one |
| msb_first | input | 1 | 1: most significant bit first; 0: least significant bit first |
| in_data | input | 8 | Message byte |
| in_valid | input | 1 | Message byte valid |
| in_last | input | 1 | Marks the final byte of a message |
| in_ready | output | 1 | Byte taken at this clock edge when `in_valid` is high |
| txd | output | 1 | Serial data out, 1 when idle |
| active | output | 1 | Line active, from the first sync bit to the last data bit |

## Verification
The checker takes for granted that upstream keeps `in_valid` high with `in_data` and `in_last` stable until `in_ready` takes the byte. The stimulus drives every byte that way, and it withholds valid only between bytes, as a deliberate stall or a gap between messages. The stimulus also picks message bytes that differ from both sync characters, so that the decoded stream can be split into pairs and data without ambiguity. It changes `msb_first` only while the line is idle, and it changes `pair_cnt` mid-run only after the run has visibly begun.

// File: rtl/sp_pkg.sv
package sp_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SYNC = 2'd1,
      ST_DATA = 2'd2
   } sp_state_t;
endpackage

// File: rtl/sp_char_shifter.sv
module sp_char_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_char,
   input  logic         rev,
   input  logic         step,
   output logic         bit_out,
   output logic         at_last
);
   localparam int IW = (W > 1) ? $clog2(W) : 1;
   localparam logic [IW-1:0] LAST_IDX = IW'(W - 1);

   logic [W-1:0]  image;
   logic [W-1:0]  flipped;
   logic [IW-1:0] idx;

   generate
      for (genvar g = 0; g < W; g++) begin : g_flip
         assign flipped[g] = load_char[W-1-g];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         image <= '1;
         idx   <= '0;
      end else if (load) begin
         image <= rev ? flipped : load_char;
         idx   <= '0;
      end else if (step && idx != LAST_IDX) begin
         idx <= idx + 1'b1;
      end
   end

   assign bit_out = image[idx];
   assign at_last = (idx == LAST_IDX);
endmodule

// File: rtl/sp_run_ctr.sv
module sp_run_ctr #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          dec,
   output logic          zero
);
   logic [CW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                left <= '0;
      else if (load)             left <= load_val;
      else if (dec && left != 0) left <= left - 1'b1;
   end

   assign zero = (left == '0);
endmodule

// File: rtl/sync_pair_framer.sv
module sync_pair_framer
   import sp_pkg::*;
#(
   parameter int CHAR_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic [CHAR_W-1:0] sync_a,
   input  logic [CHAR_W-1:0] sync_b,
   input  logic [CNT_W-1:0]  pair_cnt,
   input  logic              msb_first,
   input  logic [CHAR_W-1:0] in_data,
   input  logic              in_valid,
   input  logic              in_last,
   output logic              in_ready,
   output logic              txd,
   output logic              active
);
   generate
      if (CHAR_W < 2) begin : g_bad_w
         $error("CHAR_W must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_c
         $error("CNT_W must be at least 1");
      end
   endgenerate

   sp_state_t         state, state_n;
   logic              phase_b, phase_b_n;
   logic              cur_last;
   logic              sh_load, sh_bit, sh_last;
   logic [CHAR_W-1:0] sh_char;
   logic              ctr_load, ctr_dec, ctr_zero;
   logic              boundary;
   logic              take;

   assign boundary = bit_en && sh_last && (state != ST_IDLE);

   always_comb begin
      state_n   = state;
      phase_b_n = phase_b;
      sh_load   = 1'b0;
      sh_char   = sync_a;
      ctr_load  = 1'b0;
      ctr_dec   = 1'b0;
      in_ready  = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (in_valid) begin
               sh_load   = 1'b1;
               ctr_load  = 1'b1;
               phase_b_n = 1'b0;
               state_n   = ST_SYNC;
            end
         end
         ST_SYNC: begin
            if (boundary) begin
               sh_load = 1'b1;
               if (!phase_b) begin
                  sh_char   = sync_b;
                  phase_b_n = 1'b1;
               end else if (!ctr_zero) begin
                  ctr_dec   = 1'b1;
                  phase_b_n = 1'b0;
               end else begin
                  in_ready  = 1'b1;
                  phase_b_n = 1'b0;
                  if (in_valid) begin
                     sh_char = in_data;
                     state_n = ST_DATA;
                  end
               end
            end
         end
         ST_DATA: begin
            if (boundary) begin
               phase_b_n = 1'b0;
               if (!cur_last) begin
                  in_ready = 1'b1;
                  sh_load  = 1'b1;
                  if (in_valid) sh_char = in_data;
                  else          state_n = ST_SYNC;
               end else if (in_valid) begin
                  sh_load  = 1'b1;
                  ctr_load = 1'b1;
                  state_n  = ST_SYNC;
               end else begin
                  state_n = ST_IDLE;
               end
            end
         end
         default: state_n = ST_IDLE;
      endcase
   end

   assign take = in_ready && in_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         phase_b  <= 1'b0;
         cur_last <= 1'b0;
      end else begin
         state   <= state_n;
         phase_b <= phase_b_n;
         if (take) cur_last <= in_last;
      end
   end

   sp_char_shifter #(.W(CHAR_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sh_load),
      .load_char (sh_char),
      .rev       (msb_first),
      .step      (bit_en && state != ST_IDLE),
      .bit_out   (sh_bit),
      .at_last   (sh_last)
   );

   sp_run_ctr #(.CW(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ctr_load),
      .load_val (pair_cnt),
      .dec      (ctr_dec),
      .zero     (ctr_zero)
   );

   assign active = (state != ST_IDLE);
   assign txd    = active ? sh_bit : 1'b1;
endmodule

// File: rtl/sync_pair_framer_chk.sv
module sync_pair_framer_chk #(
   parameter int CHAR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_en,
   input logic [CHAR_W-1:0] in_data,
   input logic              in_valid,
   input logic              in_last,
   input logic              in_ready,
   input logic              txd,
   input logic              active
);
   // R4: an idle line rests at mark and offers no handshake
   p_idle_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (txd && !in_ready));

   // R6: a byte is taken only on a character boundary with a bit enable
   p_ready_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (bit_en && active));

   // R8: without an enable, the line bit does not move
   p_hold_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !bit_en) |=> (!active || $stable(txd)));

   // R9: the line drops only at the end of a bit
   p_drop_on_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !bit_en) |=> active);

   // R5: from idle, a valid byte brings the line up on the next edge
   p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && in_valid) |=> active);

   // input assumption: an offered byte is held until taken
   p_hold_offer_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready) |=> (in_valid && $stable(in_data) && $stable(in_last)));
endmodule

bind sync_pair_framer sync_pair_framer_chk #(.CHAR_W(CHAR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bit_en   (bit_en),
   .in_data  (in_data),
   .in_valid (in_valid),
   .in_last  (in_last),
   .in_ready (in_ready),
   .txd      (txd),
   .active   (active)
);

// File: tb/sync_pair_framer_tb.sv
`timescale 1ns/1ps
module sync_pair_framer_tb;
   localparam int NMSG  = 24;
   localparam int MAXL  = 6;
   localparam int NB    = NMSG * MAXL;
   localparam int NCH   = 4096;
   localparam logic [7:0] SA = 8'h32;
   localparam logic [7:0] SB = 8'hD1;

   logic       clk = 0;
   logic       rst_n = 0;
   logic       bit_en = 0;
   logic [3:0] pair_cnt = 0;
   logic       msb_first = 0;
   logic [7:0] in_data = 0;
   logic       in_valid = 0;
   logic       in_last = 0;
   logic       in_ready, txd, active;

   always #10 clk = ~clk;

   sync_pair_framer u_dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sync_a(SA), .sync_b(SB),
      .pair_cnt(pair_cnt), .msb_first(msb_first), .in_data(in_data),
      .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
      .txd(txd), .active(active));

   int errors = 0;
   int checks = 0;

   logic [7:0] bytes [NB];
   int         mstart [NMSG];
   int         mlen [NMSG];
   logic [3:0] mcnt [NMSG];
   logic       mgap [NMSG];
   logic       mpert [NMSG];
   logic [7:0] ch [NCH];
   logic       segend [NCH];
   int         nch = 0;

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pick_byte();
      logic [7:0] b;
      b = 8'($urandom);
      while (b == SA || b == SB) b = 8'($urandom);
      return b;
   endfunction

   initial begin
      int total, ptr, msg, stall, bits_since, cyc;
      int nb, p, k, fills;
      logic wait_idle, pert_arm, prev_active, prev_txd, prev_hold;
      logic [7:0] cs;
      void'($urandom(32'h5A17));
      total = 0;
      for (int m = 0; m < NMSG; m++) begin
         mstart[m] = total;
         mlen[m]   = (m == 0) ? 1 : 1 + int'($urandom % MAXL);
         mcnt[m]   = (m == 0) ? 4'd0 : (m == 1) ? 4'd15 : 4'($urandom);
         mgap[m]   = (m % 3 == 0);
         mpert[m]  = 1'b0;
         for (int j = 0; j < mlen[m]; j++) bytes[total + j] = pick_byte();
         total += mlen[m];
      end
      for (int i = 0; i < NCH; i++) segend[i] = 1'b0;

      pair_cnt = mcnt[0];
      repeat (3) @(negedge clk);
      #1;
      check(!active && txd && !in_ready, "R4 reset", {active, txd, in_ready}, 3'b010);
      rst_n = 1;

      ptr = 0; msg = 0; stall = 0; wait_idle = 0; pert_arm = 0; bits_since = 0;
      nb = 0; cs = 0; prev_active = 0; prev_txd = 1; prev_hold = 0; cyc = 0;
      while (cyc < 150000) begin
         @(negedge clk);
         cyc++;
         if (prev_hold && active)
            check(txd == prev_txd, "R8 hold", txd, prev_txd);
         if (prev_active && !active) begin
            if (nch > 0) segend[nch-1] = 1'b1;
            check(nb == 0, "R9 whole chars at drop", nb, 0);
         end
         if (!active && !prev_active && ptr > 0)
            check(txd && !in_ready, "R4 idle", {txd, in_ready}, 2'b10);
         if (ptr >= total && !active && stall == 0 && !wait_idle) break;
         bit_en = ($urandom % 2) == 1;
         if (stall > 0) begin
            in_valid = 0; stall--;
         end else if (wait_idle) begin
            in_valid = 0;
            if (!active) begin
               wait_idle = 0;
               stall = 1 + int'($urandom % 10);
               msb_first = $urandom % 2;
            end
         end else if (ptr < total) begin
            in_valid = 1;
            in_data  = bytes[ptr];
            in_last  = (ptr == mstart[msg] + mlen[msg] - 1);
         end else begin
            in_valid = 0;
         end
         #1;
         prev_active = active;
         prev_txd    = txd;
         prev_hold   = active && !bit_en;
         if (bit_en && active) begin
            cs = msb_first ? {cs[6:0], txd} : {txd, cs[7:1]};
            nb++;
            if (nb == 8) begin
               if (nch < NCH) ch[nch] = cs;
               nch++; nb = 0;
            end
            if (pert_arm) begin
               bits_since++;
               if (bits_since == 12) begin
                  pair_cnt = ~mcnt[msg];
                  pert_arm = 0;
               end
            end
         end
         if (in_valid && in_ready) begin
            if (ptr == mstart[msg] && msg + 1 < NMSG) pair_cnt = mcnt[msg + 1];
            if (in_last) begin
               if (msg + 1 < NMSG) begin
                  if (mgap[msg + 1]) wait_idle = 1;
                  else begin
                     pert_arm = 1; bits_since = 0; mpert[msg + 1] = 1;
                  end
               end
               msg++;
            end else if ($urandom % 4 == 0) begin
               stall = 20;
            end
            ptr++;
         end
      end
      if (cyc >= 150000) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      end

      p = 0;
      for (int m = 0; m < NMSG; m++) begin
         if (p >= nch || p >= NCH) begin
            check(0, "R6 stream short", p, nch);
            break;
         end
         if (m == 0 || mgap[m])
            check(ch[p] == SA, "R5 first char", ch[p], SA);
         k = 0;
         while (p + 1 < nch && p + 1 < NCH && ch[p] == SA && ch[p+1] == SB) begin
            k++; p += 2;
         end
         if (mpert[m])
            check(k == int'(mcnt[m]) + 1, "R3 run length after change", k, int'(mcnt[m]) + 1);
         else
            check(k == int'(mcnt[m]) + 1, "R1 run length", k, int'(mcnt[m]) + 1);
         if (p < NCH) check(ch[p] != SA, "R2 whole pair", ch[p], bytes[mstart[m]]);
         for (int j = 0; j < mlen[m]; j++) begin
            fills = 0;
            if (j > 0)
               while (p + 1 < nch && p + 1 < NCH && ch[p] == SA && ch[p+1] == SB) begin
                  fills++; p += 2;
               end
            if (p >= NCH) break;
            if (fills > 0)
               check(ch[p] == bytes[mstart[m] + j], "R10 resume after fill", ch[p], bytes[mstart[m] + j]);
            else if (msb_first)
               check(ch[p] == bytes[mstart[m] + j], "R6/R7 byte", ch[p], bytes[mstart[m] + j]);
            else
               check(ch[p] == bytes[mstart[m] + j], "R6 byte", ch[p], bytes[mstart[m] + j]);
            p++;
         end
         if (p > 0 && p <= NCH)
            check(segend[p-1] == (m == NMSG - 1 || mgap[m + 1 < NMSG ? m + 1 : m]),
                  "R9 line drop", segend[p-1], (m == NMSG - 1 || mgap[m + 1 < NMSG ? m + 1 : m]));
      end
      check(p == nch, "R2 no trailing chars", p, nch);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule